// File: doc/BRIEF.md
# Multiturn Sync-Bit Corrector

This block combines a turn count, received from an external multiturn sensor, with the angle measured by the local singleturn sensor. With each reading the external sensor also sends a few synchronization bits, which give its own position within one revolution. The block compares these bits with the same number of top bits of the local angle. The external sensor is mounted so that it leads the local sensor in phase. Because of this, the only possible disagreement is that the external sensor has already passed zero and counted a new turn while the local sensor has not yet reached zero. In that case the block takes one turn off the received count. It never adds a turn.

The block also checks whether the phase lead between the two sensors has left its allowed band. When this happens during normal operation, it sets a sticky multiturn error flag. The flag also drives an active-low error pin, and it stays set until software pulses a clear input. During startup a violation does not set the flag, and the count is used as it was corrected.

Two 3-bit codes configure the block. One selects the number of synchronization bits, from 1 to 5. The other selects the turn-count width, from 0 to 32 bits. A new reading is taken whenever the sample strobe is high, and the result appears on a registered output one clock later.

Top module: `mtsc_corrector`

## Requirements
- R1: After reset, `mt_out` is 0, `out_vld` is 0, `mt_err` is 0 and `mt_err_n` is 1.
- R2: When `sample_vld` is high at a rising edge, `mt_out` takes the corrected value at that edge and `out_vld` is high for exactly the following cycle. While `sample_vld` is low, `mt_out` holds its value and `out_vld` is 0.
- R3: `sync_code` values 1 to 5 select n = `sync_code` synchronization bits. The received value is `sync_in[n-1:0]`, and the bits of `sync_in` above bit n-1 are ignored. The local value is the top n bits of `st_msbs`, i.e. `st_msbs[4 -: n]`, where `st_msbs[4]` is the singleturn MSB.
- R4: When the received value is numerically smaller than the local value, the output is the received count minus one. Otherwise it is the received count unchanged.
- R5: `reso_code` k selects a turn-count width of 4*k bits for k = 1 to 6, and 32 bits for k = 7. The output is reduced modulo 2^width, so bits at and above the width read 0 and a count of 0 that is decremented gives all ones across the width.
- R6: When `sync_code` is 0, 6 or 7, or `reso_code` is 0, `mt_out` becomes 0 on a sample and no error is raised.
- R7: Let d = (received − local) mod 2^n. The phase is out of tolerance when d > 2^(n-1), or when n ≥ 2 and d = 0. With n = 1 no violation is possible.
- R8: An out-of-tolerance sample sets `mt_err` only while `startup` is low. `mt_err` stays set until `err_clr` is high at an edge. If a new violation and `err_clr` arrive at the same edge, the violation wins.
- R9: `mt_err_n` is always the inverse of `mt_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | Take one reading this cycle |
| mt_cnt_in | input | MT_W | Turn count from the external sensor |
| sync_in | input | SYNC_MAX | Synchronization bits from the external sensor, right-aligned |
| st_msbs | input | SYNC_MAX | Top bits of the local singleturn angle, MSB at the left |
| sync_code | input | 3 | Synchronization-bit count code |
| reso_code | input | 3 | Turn-count width code |
| startup | input | 1 | High during startup; suppresses error setting |
| err_clr | input | 1 | Clears the sticky error flag |
| mt_out | output | MT_W | Corrected turn count |
| out_vld | output | 1 | `mt_out` was updated at the last edge |
| mt_err | output | 1 | Sticky multiturn error, active high |
| mt_err_n | output | 1 | Error pin, active low |

## Verification
The bench sweeps every synchronization code, every 5-bit received pattern and every 5-bit local pattern. Each sample uses a varying width code and a count taken from 0, 1, all ones and scattered values. This exposes several kinds of fault:
- a design that compares the wrong slice of the local angle, or fails to ignore the upper received bits, gets the decrement wrong on half of the patterns;
- a design that decrements without wrapping at the selected width leaks bits above that width when the count is 0;
- a swapped tolerance bound shows up at d = 0 and at d = 2^(n-1).

Error clears and startup cycles fall on samples that violate tolerance as well as on samples that do not. As a result, a flag that is not sticky, a flag that lets a clear beat a new violation, or a flag raised during startup each fails a check.

// File: rtl/mtsc_pkg.sv
`timescale 1ns/1ps
package mtsc_pkg;
   localparam int unsigned MTSC_CODE_W   = 3;
   localparam int unsigned MTSC_SYNC_LIM = 5;

   typedef logic [MTSC_CODE_W-1:0] mtsc_code_t;

   // decoded configuration shared between the decoder and the top
   typedef struct packed {
      logic       en;
      logic [2:0] nsync;
      logic [7:0] res;
   } mtsc_cfg_t;

   // turn-count width for a code, limited to the datapath width
   function automatic int unsigned mtsc_res_bits(input mtsc_code_t code,
                                                 input int unsigned step,
                                                 input int unsigned top,
                                                 input int unsigned lim);
      int unsigned r;
      if (code == '0)
         r = 0;
      else if (code == '1)
         r = top;
      else
         r = step * int'(code);
      if (r > lim) r = lim;
      return r;
   endfunction

   // number of synchronization bits for a code, 0 when disabled
   function automatic int unsigned mtsc_sync_bits(input mtsc_code_t code,
                                                  input int unsigned lim);
      int unsigned n;
      n = int'(code);
      if (n > lim) n = 0;
      return n;
   endfunction
endpackage

// File: rtl/mtsc_cfg_decode.sv
`timescale 1ns/1ps
module mtsc_cfg_decode
   import mtsc_pkg::*;
#(
   parameter int unsigned MT_W     = 32,
   parameter int unsigned SYNC_MAX = 5,
   parameter int unsigned RES_STEP = 4,
   parameter int unsigned RES_TOP  = 32
) (
   input  logic [MTSC_CODE_W-1:0] sync_code,
   input  logic [MTSC_CODE_W-1:0] reso_code,
   output mtsc_cfg_t              cfg,
   output logic [MT_W-1:0]        res_mask
);
   int unsigned res_w;
   int unsigned sync_n;

   always_comb begin
      res_w     = mtsc_res_bits(reso_code, RES_STEP, RES_TOP, MT_W);
      sync_n    = mtsc_sync_bits(sync_code, SYNC_MAX);
      cfg.res   = 8'(res_w);
      cfg.nsync = 3'(sync_n);
      cfg.en    = (res_w != 0) && (sync_n != 0);
   end

   // thermometer mask of the active turn-count bits
   for (genvar b = 0; b < MT_W; b++) begin : g_mask
      assign res_mask[b] = (res_w > b);
   end
endmodule

// File: rtl/mtsc_phase_cmp.sv
`timescale 1ns/1ps
module mtsc_phase_cmp #(
   parameter int unsigned SYNC_MAX = 5
) (
   input  logic [SYNC_MAX-1:0] sync_in,
   input  logic [SYNC_MAX-1:0] st_msbs,
   input  logic [2:0]          nsync,
   output logic                wrap,
   output logic                viol
);
   logic [SYNC_MAX:1] wrap_v;
   logic [SYNC_MAX:1] viol_v;

   // one comparator per possible sync-bit count
   for (genvar g = 1; g <= SYNC_MAX; g++) begin : g_width
      localparam int unsigned HALF = 1 << (g - 1);
      logic [g-1:0] rx_v;
      logic [g-1:0] lc_v;
      logic [g-1:0] diff;
      logic         far;

      assign rx_v = sync_in[g-1:0];
      assign lc_v = st_msbs[SYNC_MAX-1 -: g];
      assign diff = rx_v - lc_v;
      assign far  = ({1'b0, diff} > (g+1)'(HALF));
      assign wrap_v[g] = (rx_v < lc_v);

      if (g >= 2) begin : g_multi
         assign viol_v[g] = far || (diff == '0);
      end else begin : g_single
         assign viol_v[g] = far;
      end
   end

   always_comb begin
      wrap = 1'b0;
      viol = 1'b0;
      for (int k = 1; k <= SYNC_MAX; k++) begin
         if (nsync == 3'(k)) begin
            wrap = wrap_v[k];
            viol = viol_v[k];
         end
      end
   end
endmodule

// File: rtl/mtsc_turn_adj.sv
`timescale 1ns/1ps
module mtsc_turn_adj #(
   parameter int unsigned MT_W       = 32,
   parameter bit          RIPPLE_DEC = 1'b0
) (
   input  logic [MT_W-1:0] cnt,
   input  logic            dec,
   input  logic [MT_W-1:0] mask,
   output logic [MT_W-1:0] adj
);
   logic [MT_W-1:0] raw;

   if (RIPPLE_DEC) begin : g_ripple
      // explicit borrow chain
      logic [MT_W:0] brw;
      assign brw[0] = dec;
      for (genvar i = 0; i < MT_W; i++) begin : g_bit
         assign raw[i]   = cnt[i] ^ brw[i];
         assign brw[i+1] = brw[i] & ~cnt[i];
      end
   end else begin : g_sub
      assign raw = cnt - MT_W'(dec);
   end

   assign adj = raw & mask;
endmodule

// File: rtl/mtsc_corrector.sv
`timescale 1ns/1ps
module mtsc_corrector
   import mtsc_pkg::*;
#(
   parameter int unsigned MT_W       = 32,
   parameter int unsigned SYNC_MAX   = 5,
   parameter int unsigned RES_STEP   = 4,
   parameter int unsigned RES_TOP    = 32,
   parameter bit          RIPPLE_DEC = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sample_vld,
   input  logic [MT_W-1:0]        mt_cnt_in,
   input  logic [SYNC_MAX-1:0]    sync_in,
   input  logic [SYNC_MAX-1:0]    st_msbs,
   input  logic [MTSC_CODE_W-1:0] sync_code,
   input  logic [MTSC_CODE_W-1:0] reso_code,
   input  logic                   startup,
   input  logic                   err_clr,
   output logic [MT_W-1:0]        mt_out,
   output logic                   out_vld,
   output logic                   mt_err,
   output logic                   mt_err_n
);
   // elaboration-time parameter checks
   if (SYNC_MAX < 1 || SYNC_MAX > MTSC_SYNC_LIM) begin : g_bad_sync
      $error("mtsc_corrector: SYNC_MAX out of range");
   end
   if (MT_W < 1) begin : g_bad_w
      $error("mtsc_corrector: MT_W must be positive");
   end
   if (RES_STEP * 6 > RES_TOP) begin : g_bad_res
      $error("mtsc_corrector: RES_TOP below largest stepped width");
   end

   mtsc_cfg_t       cfg;
   logic [MT_W-1:0] res_mask;
   logic            wrap;
   logic            viol;
   logic [MT_W-1:0] adj;
   logic            set_err;

   logic [MT_W-1:0] mt_q;
   logic            vld_q;
   logic            err_q;

   mtsc_cfg_decode #(
      .MT_W(MT_W), .SYNC_MAX(SYNC_MAX), .RES_STEP(RES_STEP), .RES_TOP(RES_TOP)
   ) i_cfg (
      .sync_code(sync_code),
      .reso_code(reso_code),
      .cfg(cfg),
      .res_mask(res_mask)
   );

   mtsc_phase_cmp #(.SYNC_MAX(SYNC_MAX)) i_cmp (
      .sync_in(sync_in),
      .st_msbs(st_msbs),
      .nsync(cfg.nsync),
      .wrap(wrap),
      .viol(viol)
   );

   mtsc_turn_adj #(.MT_W(MT_W), .RIPPLE_DEC(RIPPLE_DEC)) i_adj (
      .cnt(mt_cnt_in),
      .dec(wrap),
      .mask(res_mask),
      .adj(adj)
   );

   assign set_err = sample_vld & cfg.en & ~startup & viol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mt_q  <= '0;
         vld_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         vld_q <= sample_vld;
         if (sample_vld) mt_q <= cfg.en ? adj : '0;
         if (set_err)      err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
      end
   end

   assign mt_out   = mt_q;
   assign out_vld  = vld_q;
   assign mt_err   = err_q;
   assign mt_err_n = ~err_q;
endmodule

// File: rtl/mtsc_corrector_chk.sv
`timescale 1ns/1ps
module mtsc_corrector_chk #(
   parameter int unsigned MT_W     = 32,
   parameter int unsigned SYNC_MAX = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sample_vld,
   input logic [MT_W-1:0]     mt_cnt_in,
   input logic [SYNC_MAX-1:0] sync_in,
   input logic [SYNC_MAX-1:0] st_msbs,
   input logic [2:0]          sync_code,
   input logic [2:0]          reso_code,
   input logic                startup,
   input logic                err_clr,
   input logic [MT_W-1:0]     mt_out,
   input logic                out_vld,
   input logic                mt_err
);
   logic dis_cfg;
   assign dis_cfg = (reso_code == 3'd0) || (int'(sync_code) > SYNC_MAX) || (sync_code == 3'd0);

   a_r2_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld |=> out_vld);
   a_r2_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_vld |=> !out_vld);
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_vld |=> $stable(mt_out));
   a_r6_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_vld && dis_cfg) |=> (mt_out == '0));
   a_r6_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_vld && dis_cfg && !mt_err) |=> !mt_err);
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (mt_err && !err_clr) |=> mt_err);
   a_r8_startup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!mt_err && (!sample_vld || startup)) |=> !mt_err);
   a_r5_width4: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_vld && reso_code == 3'd1) |=> ((mt_out >> 4) == '0));

   if (MT_W == 32) begin : g_full
      a_r4_pass: assert property (@(posedge clk) disable iff (!rst_n)
         (sample_vld && int'(sync_code) == SYNC_MAX && reso_code == 3'd7 && sync_in >= st_msbs)
         |=> (mt_out == $past(mt_cnt_in)));
   end
endmodule

bind mtsc_corrector mtsc_corrector_chk #(.MT_W(MT_W), .SYNC_MAX(SYNC_MAX)) i_chk (
   .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .mt_cnt_in(mt_cnt_in),
   .sync_in(sync_in), .st_msbs(st_msbs), .sync_code(sync_code), .reso_code(reso_code),
   .startup(startup), .err_clr(err_clr), .mt_out(mt_out), .out_vld(out_vld),
   .mt_err(mt_err)
);

// File: tb/test_mtsc_corrector.sv
`timescale 1ns/1ps
module test_mtsc_corrector;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_vld = 1'b0;
   logic [31:0] mt_cnt_in = '0;
   logic [4:0]  sync_in = '0;
   logic [4:0]  st_msbs = '0;
   logic [2:0]  sync_code = '0;
   logic [2:0]  reso_code = '0;
   logic        startup = 1'b0;
   logic        err_clr = 1'b0;
   logic [31:0] mt_out;
   logic        out_vld;
   logic        mt_err;
   logic        mt_err_n;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic err_exp = 1'b0;

   always #4 clk = ~clk;

   mtsc_corrector i_mtsc_corrector (
      .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .mt_cnt_in(mt_cnt_in),
      .sync_in(sync_in), .st_msbs(st_msbs), .sync_code(sync_code), .reso_code(reso_code),
      .startup(startup), .err_clr(err_clr), .mt_out(mt_out), .out_vld(out_vld),
      .mt_err(mt_err), .mt_err_n(mt_err_n)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // arithmetic model of one sample
   task automatic model(input int sc, input int sv, input int lv, input int rc,
                        input logic [31:0] cnt, input bit st,
                        output logic [31:0] o, output bit v);
      int n, r, loc, s, d, m;
      bit en, wr;
      logic [31:0] mask;
      n  = (sc >= 1 && sc <= 5) ? sc : 0;
      r  = (rc == 0) ? 0 : ((rc == 7) ? 32 : 4 * rc);
      en = (n != 0) && (r != 0);
      o  = '0;
      v  = 1'b0;
      if (en) begin
         m    = 1 << n;
         loc  = lv >> (5 - n);
         s    = sv % m;
         wr   = s < loc;
         d    = (s - loc + m) % m;
         mask = (r == 32) ? 32'hFFFF_FFFF : ((32'h1 << r) - 32'h1);
         o    = (cnt - 32'(wr)) & mask;
         v    = !st && ((d > (m / 2)) || (n >= 2 && d == 0));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] exp_o;
      bit          exp_v;
      int          idx;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 mt_out", mt_out, 32'h0);
      check("R1 out_vld", 32'(out_vld), 32'h0);
      check("R1 mt_err", 32'(mt_err), 32'h0);
      check("R1 mt_err_n", 32'(mt_err_n), 32'h1);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 directed: single sample, then hold with changing inputs
      sync_code = 3'd5; reso_code = 3'd7; mt_cnt_in = 32'h1234_5678;
      sync_in = 5'd20; st_msbs = 5'd3; startup = 1'b1; sample_vld = 1'b1;
      @(negedge clk);
      sample_vld = 1'b0;
      check("R2 out_vld pulse", 32'(out_vld), 32'h1);
      check("R2 value", mt_out, 32'h1234_5678);
      mt_cnt_in = 32'hDEAD_BEEF; st_msbs = 5'd31;
      @(negedge clk);
      check("R2 out_vld drop", 32'(out_vld), 32'h0);
      check("R2 hold", mt_out, 32'h1234_5678);

      // R8 directed: sticky error, clear, and set-over-clear
      startup = 1'b0; sync_code = 3'd2; sync_in = 5'd0; st_msbs = 5'd0; sample_vld = 1'b1;
      @(negedge clk);
      sample_vld = 1'b0;
      check("R7 d=0 violation", 32'(mt_err), 32'h1);
      check("R9 pin low", 32'(mt_err_n), 32'h0);
      repeat (3) @(negedge clk);
      check("R8 sticky", 32'(mt_err), 32'h1);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      check("R8 clear", 32'(mt_err), 32'h0);
      err_clr = 1'b1; sample_vld = 1'b1;
      @(negedge clk);
      err_clr = 1'b0; sample_vld = 1'b0;
      check("R8 set wins", 32'(mt_err), 32'h1);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      err_exp = 1'b0;

      // near-exhaustive sweep: R3 R4 R5 R6 R7 R8 R9
      idx = 0;
      for (int sc = 0; sc < 8; sc++) begin
         for (int sv = 0; sv < 32; sv++) begin
            for (int lv = 0; lv < 32; lv++) begin
               logic [31:0] cnt;
               int rc;
               case (idx % 4)
                  0: cnt = 32'h0;
                  1: cnt = 32'h1;
                  2: cnt = 32'hFFFF_FFFF;
                  default: cnt = 32'(idx) * 32'h9E37_79B1;
               endcase
               rc = (idx / 3) % 8;
               sync_code = 3'(sc); reso_code = 3'(rc);
               sync_in = 5'(sv); st_msbs = 5'(lv); mt_cnt_in = cnt;
               startup = (idx % 7 == 0);
               err_clr = (idx % 5 == 0);
               sample_vld = 1'b1;
               model(sc, sv, lv, rc, cnt, startup, exp_o, exp_v);
               if (exp_v) err_exp = 1'b1;
               else if (err_clr) err_exp = 1'b0;
               @(negedge clk);
               sample_vld = 1'b0; err_clr = 1'b0;
               check("R3/R4/R5/R6 mt_out", mt_out, exp_o);
               check("R7/R8 mt_err", 32'(mt_err), 32'(err_exp));
               check("R9 mt_err_n", 32'(mt_err_n), 32'(!err_exp));
               idx++;
            end
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule